// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends characters as non-return-to-zero frames on a single transmit line. A host hands it one character at a time through a one-cycle write strobe. The character goes into a holding register. From there the block's state machine moves it into a shift register and sends it: one low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. The holding register sits in front of the shift register. A host that refills it while a frame is on the line gets frames with no idle gap between them.

A built-in bit-rate generator sets the bit period. The host supplies a divisor `n`. It also picks the divisor width (only the low byte, or the full word) and a speed setting. Together these give a bit period of 64, 16 or 4 times `(n+1)` clock cycles. The host can also ask for a break character, or invert the line. Clearing the enable stops everything at once.

The state machine has five states:
- `ST_IDLE`: the line rests high and the rate generator is held cleared.
- `ST_START`: the start bit is on the line.
- `ST_DATA`: the data bits are on the line.
- `ST_STOP`: the stop bit is on the line.
- `ST_BREAK`: the line is held low for one frame time.

Transitions:
- idle→break when a break is pending; otherwise idle→start when the holding register is full.
- start→data on a bit tick.
- data→stop on the tick that ends the last data bit.
- stop→break, stop→start or stop→idle on a tick. The choice follows the same priority as in idle: break first, then held data, then idle.
- break→idle after the tick that ends the last bit position of the break.
- Any state goes to idle when the enable is low.

Top module: `sertx_top`

## Requirements
- R1: After reset and between frames the line is high. A frame is a low start bit, then data bits LSB first, then a high stop bit. With `cfg_nine` low there are 8 data bits.
- R2: With `cfg_nine` high, a ninth data bit follows data bit 7 and precedes the stop bit. Its value is `cfg_bit9` as sampled on the cycle of the accepted write, not its later value.
- R3: A write made while the transmitter is idle reaches the line within two clock edges. On the second edge `hold_empty` is high, `shift_empty` is low and the start bit is on the line.
- R4: `hold_empty` goes low only on an accepted write; nothing else clears it. A write made while the holding register is full is ignored, and its character is never sent.
- R5: A character held when a stop bit ends starts its start bit on the very next cycle. The next frame therefore begins exactly `(bits+2)` bit periods after the previous start.
- R6: `shift_empty` is high after reset. It goes low while a frame or break is on the line, and goes high again once the last stop-bit period has ended.
- R7: The bit period, in clock cycles, is `64(n+1)` when `cfg_wide`=0 and `cfg_fast`=0. It is `16(n+1)` when exactly one of `cfg_wide` and `cfg_fast` is set, and `4(n+1)` when both are set. With `cfg_wide` low, only `cfg_div[7:0]` forms `n`.
- R8: The divisor is read at every generator reload. A value changed while the line is idle sets the full timing of the next frame.
- R9: With `cfg_invert` high the line carries the complement of every level above, and idles low.
- R10: A one-cycle `brk_req` sets `brk_pending`. When the transmitter next chooses a frame, `brk_pending` clears and the line is driven low for `(bits+2)` bit periods, where a normal frame's stop bit would be high. The line then returns to idle.
- R11: While `cfg_en` is low, any frame is cut off and the line is idle high within one cycle. Both empty flags are high, held data and pending breaks are discarded, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_en | input | 1 | transmitter enable |
| cfg_nine | input | 1 | 9 data bits per frame when high |
| cfg_bit9 | input | 1 | ninth data bit, captured with each write |
| cfg_invert | input | 1 | invert the transmit line |
| cfg_fast | input | 1 | speed setting of the rate generator |
| cfg_wide | input | 1 | use the full-width divisor when high, low byte otherwise |
| cfg_div | input | DIV_W | divisor n |
| wr_valid | input | 1 | one-cycle write strobe |
| wr_data | input | DATA_W | character to send |
| brk_req | input | 1 | one-cycle break request |
| brk_pending | output | 1 | a break is waiting to be sent |
| hold_empty | output | 1 | holding register can take a write |
| shift_empty | output | 1 | nothing is being shifted out |
| tx_line | output | 1 | serial output |

## Verification
Some properties are checked on every cycle:
- a clear of the rate generator is never followed by a tick on the next cycle;
- the holding register fills only from a write, and is never emptied by a write that finds it full;
- an idle state machine with held data starts a frame on the next edge;
- a break that begins has consumed its request;
- a low enable empties both flags one cycle later.

Other behaviour can only be shown by the bench's scenarios: the bit order on the line, the exact period in each of the three rate settings, the gap-free timing between frames, when the ninth bit is captured, inversion, and the full length of a break. The bench's monitor decodes the line against expected frames, and it flags any frame it does not expect.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK
    } tx_state_e;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wide,
    input  logic             fast,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int LO_W  = DIV_W / 2;
    localparam int PRE_W = 6;

    logic [DIV_W-1:0] cnt, reload;
    logic [PRE_W-1:0] pre, pre_top;

    always_comb begin
        reload = wide ? div : {{(DIV_W-LO_W){1'b0}}, div[LO_W-1:0]};
        case ({wide, fast})
            2'b00:   pre_top = PRE_W'(63);
            2'b11:   pre_top = PRE_W'(3);
            default: pre_top = PRE_W'(15);
        endcase
    end

    assign tick = !clr && (cnt == '0) && (pre == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            pre <= '0;
        end else if (clr) begin
            cnt <= reload;
            pre <= pre_top;
        end else if (cnt == '0) begin
            cnt <= reload;
            pre <= (pre == '0) ? pre_top : pre - 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7: a cleared generator never ticks on the following cycle
    p_no_tick_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_b9,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              b9
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            b9   <= 1'b0;
        end else if (!en) begin
            full <= 1'b0;
        end else if (wr && !full) begin
            full <= 1'b1;
            data <= wr_data;
            b9   <= wr_b9;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R4: the register fills only from a write
    p_fill_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr));
    // R4: a write that finds the register full does not disturb it
    p_full_write_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !take && en) |=> (full && $stable(data)));
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              nine,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_b9,
    input  logic              brk_req,
    output logic              take,
    output logic              brk_pend,
    output logic              baud_clr,
    output logic              shift_idle,
    output logic              line_raw
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 3);

    tx_state_e         st, nxt;
    logic [SH_W-1:0]   shreg;
    logic [CNT_W-1:0]  bit_cnt, last_data, last_brk;
    logic              brk_go, load;

    assign last_data = nine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    assign last_brk  = last_data + CNT_W'(2);

    // next-state selection
    always_comb begin
        nxt    = st;
        take   = 1'b0;
        brk_go = 1'b0;
        load   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (brk_pend) begin
                    nxt = ST_BREAK; brk_go = 1'b1;
                end else if (hold_full) begin
                    nxt = ST_START; take = 1'b1; load = 1'b1;
                end
            end
            ST_START: if (tick) nxt = ST_DATA;
            ST_DATA:  if (tick && bit_cnt == last_data) nxt = ST_STOP;
            ST_STOP: begin
                if (tick) begin
                    if (brk_pend) begin
                        nxt = ST_BREAK; brk_go = 1'b1;
                    end else if (hold_full) begin
                        nxt = ST_START; take = 1'b1; load = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_BREAK: if (tick && bit_cnt == last_brk) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!en) begin
            nxt = ST_IDLE; take = 1'b0; brk_go = 1'b0; load = 1'b0;
        end
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            brk_pend <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt != st)
                bit_cnt <= '0;
            else if (tick && (st == ST_DATA || st == ST_BREAK))
                bit_cnt <= bit_cnt + 1'b1;
            if (load)
                shreg <= {hold_b9 & nine, hold_data};
            else if (tick && st == ST_DATA)
                shreg <= {1'b0, shreg[SH_W-1:1]};
            if (!en)          brk_pend <= 1'b0;
            else if (brk_req) brk_pend <= 1'b1;
            else if (brk_go)  brk_pend <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_IDLE:  line_raw = 1'b1;
            ST_START: line_raw = 1'b0;
            ST_DATA:  line_raw = shreg[0];
            ST_STOP:  line_raw = 1'b1;
            ST_BREAK: line_raw = 1'b0;
            default:  line_raw = 1'b1;
        endcase
        shift_idle = (st == ST_IDLE);
        baud_clr   = (st == ST_IDLE) || !en;
    end

    // R3: idle with held data starts a frame on the next edge
    p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && hold_full && en && !brk_pend) |=> (st == ST_START));
    // R10: entering a break consumes the request
    p_break_consumes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BREAK && $past(st) != ST_BREAK && !$past(brk_req)) |-> !brk_pend);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_nine,
    input  logic              cfg_bit9,
    input  logic              cfg_invert,
    input  logic              cfg_fast,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_req,
    output logic              brk_pending,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              tx_line
);
    logic              tick, baud_clr, take, hold_full, hold_b9, line_raw, shift_idle;
    logic [DATA_W-1:0] hold_data;

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .clr(baud_clr), .wide(cfg_wide),
        .fast(cfg_fast), .div(cfg_div), .tick(tick)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .wr(wr_valid),
        .wr_data(wr_data), .wr_b9(cfg_bit9), .take(take),
        .full(hold_full), .data(hold_data), .b9(hold_b9)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .nine(cfg_nine), .tick(tick),
        .hold_full(hold_full), .hold_data(hold_data), .hold_b9(hold_b9),
        .brk_req(brk_req), .take(take), .brk_pend(brk_pending),
        .baud_clr(baud_clr), .shift_idle(shift_idle), .line_raw(line_raw)
    );

    assign hold_empty  = !hold_full;
    assign shift_empty = shift_idle;
    assign tx_line     = line_raw ^ cfg_invert;

    // R11: a low enable leaves both flags set one cycle later
    p_disable_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (hold_empty && shift_empty));
    // R4: the holding flag only drops after a write strobe
    p_hold_flag_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(wr_valid));
endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [8:0]  bits;
        logic [3:0]  nb;
        logic [15:0] per;
        logic        brk;
        logic        b2b;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_nine = 1'b0, cfg_bit9 = 1'b0, cfg_invert = 1'b0;
    logic cfg_fast = 1'b1, cfg_wide = 1'b1;
    logic [15:0] cfg_div = 16'd1;
    logic wr_valid = 1'b0, brk_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic brk_pending, hold_empty, shift_empty, tx_line;

    int tests = 0, fails = 0;
    int cyc = 0;
    bit mon_off = 1'b0, mon_busy = 1'b0, done = 1'b0;
    longint last_end = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sertx_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_nine(cfg_nine),
        .cfg_bit9(cfg_bit9), .cfg_invert(cfg_invert), .cfg_fast(cfg_fast),
        .cfg_wide(cfg_wide), .cfg_div(cfg_div), .wr_valid(wr_valid),
        .wr_data(wr_data), .brk_req(brk_req), .brk_pending(brk_pending),
        .hold_empty(hold_empty), .shift_empty(shift_empty), .tx_line(tx_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int period(input logic w, input logic f, input logic [15:0] d);
        int m, n;
        m = (!w && !f) ? 64 : (w && f) ? 4 : 16;
        n = w ? int'(d) : int'(d[7:0]);
        return m * (n + 1);
    endfunction

    // driver: push an expected frame built from the current settings
    task automatic expect_frame(input logic [7:0] d, input logic b9, input bit b2b, input bit brk);
        exp_t e;
        e.nb   = cfg_nine ? 4'd9 : 4'd8;
        e.bits = brk ? 9'd0 : {b9 & cfg_nine, d};
        e.per  = 16'(period(cfg_wide, cfg_fast, cfg_div));
        e.brk  = brk;
        e.b2b  = b2b;
        exp_q.push_back(e);
    endtask

    task automatic write(input logic [7:0] d);
        wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0 || mon_busy || !shift_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: decode the line and compare with the queue (R1 R2 R5 R7 R9 R10)
    initial begin
        exp_t e;
        int   p, t0;
        bit   ok;
        logic lv;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (!mon_off && (tx_line ^ cfg_invert) == 1'b0) begin
                mon_busy = 1'b1;
                t0 = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame on line", 1, 0);
                    repeat (20) @(negedge clk);
                end else begin
                    e  = exp_q.pop_front();
                    p  = int'(e.per);
                    ok = 1'b1;
                    if (e.b2b)
                        chk(longint'(t0) == last_end, "R5 back-to-back start cycle", t0, int'(last_end));
                    repeat (p/2) @(negedge clk);
                    if ((tx_line ^ cfg_invert) != 1'b0) ok = 1'b0;
                    for (int i = 0; i < int'(e.nb); i++) begin
                        repeat (p) @(negedge clk);
                        lv = tx_line ^ cfg_invert;
                        if (lv !== e.bits[i]) ok = 1'b0;
                    end
                    repeat (p) @(negedge clk);
                    lv = tx_line ^ cfg_invert;
                    if (lv !== !e.brk) ok = 1'b0;
                    chk(ok, e.brk ? "R10 break frame" : "R1/R2/R7 frame bits", int'(e.bits), int'(e.bits));
                    last_end = longint'(t0) + longint'(p) * (int'(e.nb) + 2);
                    repeat (p - p/2 - 1) @(negedge clk);
                end
                mon_busy = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R6 reset state
        chk(tx_line == 1'b1, "R1 idle line after reset", tx_line, 1);
        chk(hold_empty && shift_empty, "R6 flags after reset", {hold_empty, shift_empty}, 3);
        cfg_en = 1'b1;
        @(negedge clk);

        // R3 single write while idle, P=8
        expect_frame(8'hA5, 1'b0, 1'b0, 1'b0);
        write(8'hA5);
        @(negedge clk);
        chk(hold_empty && !shift_empty && tx_line == 1'b0, "R3 load on second edge",
            {hold_empty, shift_empty, tx_line}, 3'b100);
        wait_done();
        chk(shift_empty == 1'b1, "R6 shift empty after stop", shift_empty, 1);

        // R4/R5 fill holding, drop a write while full, frames back to back
        expect_frame(8'h11, 1'b0, 1'b0, 1'b0);
        expect_frame(8'h22, 1'b0, 1'b1, 1'b0);
        write(8'h11);
        @(negedge clk);
        write(8'h22);
        chk(hold_empty == 1'b0, "R4 holding full after write", hold_empty, 0);
        write(8'h33);
        chk(hold_empty == 1'b0, "R4 full write ignored", hold_empty, 0);
        wait_done();
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0 && tx_line == 1'b1, "R4 dropped byte not sent", tx_line, 1);

        // R2 nine-bit mode, bit captured at write
        cfg_nine = 1'b1; cfg_bit9 = 1'b1;
        expect_frame(8'h5A, 1'b1, 1'b0, 1'b0);
        write(8'h5A);
        cfg_bit9 = 1'b0;
        @(negedge clk);
        expect_frame(8'hFF, 1'b0, 1'b1, 1'b0);
        write(8'hFF);
        cfg_bit9 = 1'b1;
        wait_done();
        cfg_nine = 1'b0; cfg_bit9 = 1'b0;

        // R7 rate settings
        cfg_wide = 1'b0; cfg_fast = 1'b0; cfg_div = 16'd0;
        expect_frame(8'h81, 1'b0, 1'b0, 1'b0); write(8'h81); wait_done();
        cfg_wide = 1'b0; cfg_fast = 1'b1; cfg_div = 16'h0100;
        expect_frame(8'h7E, 1'b0, 1'b0, 1'b0); write(8'h7E); wait_done();
        cfg_wide = 1'b1; cfg_fast = 1'b0; cfg_div = 16'd2;
        expect_frame(8'h96, 1'b0, 1'b0, 1'b0); write(8'h96); wait_done();
        // R8 divisor changed while idle governs the next frame
        cfg_wide = 1'b1; cfg_fast = 1'b1; cfg_div = 16'd3;
        expect_frame(8'h0F, 1'b0, 1'b0, 1'b0); write(8'h0F); wait_done();
        cfg_div = 16'd1;

        // R9 inversion
        cfg_invert = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_line == 1'b0, "R9 inverted idle level", tx_line, 0);
        expect_frame(8'hC4, 1'b0, 1'b0, 1'b0); write(8'hC4); wait_done();
        cfg_invert = 1'b0;
        @(negedge clk);

        // R10 break
        expect_frame(8'h00, 1'b0, 1'b0, 1'b1);
        brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
        chk(brk_pending == 1'b1, "R10 break pending set", brk_pending, 1);
        @(negedge clk);
        chk(brk_pending == 1'b0 && tx_line == 1'b0, "R10 break started and request cleared",
            {brk_pending, tx_line}, 0);
        wait_done();
        chk(tx_line == 1'b1, "R10 idle after break", tx_line, 1);

        // R11 disable mid-frame
        mon_off = 1'b1;
        write(8'h00);
        repeat (20) @(negedge clk);
        write(8'hAB);
        cfg_en = 1'b0;
        @(negedge clk);
        chk(tx_line && hold_empty && shift_empty, "R11 abort to idle",
            {tx_line, hold_empty, shift_empty}, 3'b111);
        write(8'h55);
        chk(hold_empty == 1'b1, "R11 write ignored while disabled", hold_empty, 1);
        cfg_en = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tx_line != 1'b1 || !shift_empty) ok = 1'b0;
        end
        chk(ok, "R11 discarded data never sent", ok, 1);
        mon_off = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule